// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that software controls through four word registers on a simple single-cycle bus: an address, a write strobe with write data, and combinational read data. After software sets the enable bit, a down-counter loads a period of 2^(EXP_BASE+n) clock cycles and then counts down by one on every clock. Here n is a 4-bit range code held in a register. The default EXP_BASE is 16, so the period runs from 65536 cycles up to 2^31 cycles.

Software keeps the system alive by writing a fixed key word to the restart register before the count runs out. A write of any other value to that register does nothing. Once enabled, the watchdog cannot be turned off by software; only reset stops it. If the counter reaches zero, the timeout output rises and stays high until reset, and the counter stays at zero. From then on, restart writes have no effect.

The register is chosen by address bits [3:2], and address bits [1:0] are ignored. All bus writes take effect at the rising clock edge where the write strobe is high.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the watchdog is disabled, the count reads 0, the range code reads 0 and timeout_o is low. While disabled, the count stays 0.
- R2: Writing data with bit 0 = 1 to offset 0x00 while the watchdog is disabled enables it. On the same edge, the counter loads 2^(EXP_BASE+n), where n is the range code stored at that moment.
- R3: The enable bit is sticky. Writing 0 to offset 0x00 leaves the watchdog enabled, and counting goes on undisturbed.
- R4: Offset 0x04 holds the range code in bits [3:0]. Write data bits above bit 3 are dropped, and a read returns the code with zeros above it.
- R5: While the watchdog is enabled and the count is nonzero, the count falls by exactly one per clock.
- R6: Writing the word 0x76 to offset 0x0C while the watchdog is enabled and the count is nonzero reloads the counter to 2^(EXP_BASE+n), using the current range code. A change to the range code alone never reloads the counter.
- R7: Writing any value other than 0x76 to offset 0x0C has no effect on the count.
- R8: On the edge where the count steps from 1 to 0, timeout_o rises. From then until reset, timeout_o stays high, the count stays 0 and restart writes are ignored.
- R9: Reads are decoded as follows. Offset 0x00 returns the enable bit in bit 0. Offset 0x04 returns the range code. Offset 0x08 returns the live count. Offset 0x0C returns 0. Address bits [1:0] are ignored.
- R10: The count register is read-only. A write to offset 0x08 does not change the count.
- R11: A key write to offset 0x0C while the watchdog is disabled is ignored: the count stays 0 and the watchdog stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_wr_data | input | DATA_W | Write data |
| bus_rd_data | output | DATA_W | Combinational read data for bus_addr |
| timeout_o | output | 1 | High once the counter has expired, until reset |

## Verification
The bench runs with a reduced exponent base of 2, so periods are short. It walks a table of range codes with restart writes. Each code is followed by a different idle wait, which separates a correct period shift from an off-by-one exponent, and a correct per-clock decrement from a skipped or doubled step.

Directed tests then try the following:
- a clearing write to the control register
- near-miss key values, including one that differs from the key only in a high bit
- writes to the read-only count register
- a range change without a restart

In each of these the count must simply keep falling by one, which exposes any unintended reload. The expiry test counts the exact edge on which timeout rises, then checks that a later key write can neither revive the counter nor clear the flag. Finally, a key write after reset confirms that a disabled block ignores restarts.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  // Register select taken from address bits [3:2].
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_RANGE = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_KICK  = 2'd3
  } kwd_sel_e;

  // Word that must be written to the restart register to reload the counter.
  localparam logic [31:0] KWD_KICK_KEY = 32'h0000_0076;

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int RANGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr_en,
  input  logic [DATA_W-1:0]  bus_wr_data,
  input  logic               cnt_zero,
  output logic               en_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               load_o
);

  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(KWD_KICK_KEY);

  kwd_sel_e   sel;
  logic       en_q;
  logic [RANGE_W-1:0] range_q;
  logic       wr_ctrl, wr_range, wr_kick;
  logic       start_evt, kick_evt;

  assign sel      = kwd_sel_e'(bus_addr[3:2]);
  assign wr_ctrl  = bus_wr_en && (sel == SEL_CTRL);
  assign wr_range = bus_wr_en && (sel == SEL_RANGE);
  assign wr_kick  = bus_wr_en && (sel == SEL_KICK);

  // Enable only ever goes from 0 to 1; a second set while running is a no-op.
  assign start_evt = wr_ctrl && bus_wr_data[0] && !en_q;
  // The key reloads only a live counter; a disabled or expired one ignores it.
  assign kick_evt  = wr_kick && (bus_wr_data == KEY_W) && en_q && !cnt_zero;
  assign load_o    = start_evt || kick_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      range_q <= '0;
    end else begin
      if (start_evt) en_q    <= 1'b1;
      if (wr_range)  range_q <= bus_wr_data[RANGE_W-1:0];
    end
  end

  assign en_o    = en_q;
  assign range_o = range_q;

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W    = 32,
  parameter int RANGE_W  = 4,
  parameter int EXP_BASE = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RANGE_W-1:0] range,
  input  logic               load,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               cnt_zero_o,
  output logic               timeout_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;
  logic             to_q;

  // The period is one set bit at position EXP_BASE + range.
  assign period = ONE << (EXP_BASE + int'(range));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (load) begin
      cnt_q <= period;
    end else if (en && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) to_q <= 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign timeout_o  = to_q;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int RANGE_W  = 4,
  parameter int EXP_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wr_data,
  output logic [DATA_W-1:0] bus_rd_data,
  output logic              timeout_o
);

  // The counter must hold the largest period, 2^(EXP_BASE + 2^RANGE_W - 1).
  localparam int CNT_W = EXP_BASE + (1 << RANGE_W);

  logic               en_q;
  logic [RANGE_W-1:0] range_q;
  logic               load;
  logic [CNT_W-1:0]   cnt_q;
  logic               cnt_zero;

  kwd_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .RANGE_W(RANGE_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr_en  (bus_wr_en),
    .bus_wr_data(bus_wr_data),
    .cnt_zero   (cnt_zero),
    .en_o       (en_q),
    .range_o    (range_q),
    .load_o     (load)
  );

  kwd_counter #(
    .CNT_W   (CNT_W),
    .RANGE_W (RANGE_W),
    .EXP_BASE(EXP_BASE)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .range     (range_q),
    .load      (load),
    .cnt_o     (cnt_q),
    .cnt_zero_o(cnt_zero),
    .timeout_o (timeout_o)
  );

  always_comb begin
    unique case (kwd_sel_e'(bus_addr[3:2]))
      SEL_CTRL:  bus_rd_data = DATA_W'(en_q);
      SEL_RANGE: bus_rd_data = DATA_W'(range_q);
      SEL_COUNT: bus_rd_data = DATA_W'(cnt_q);
      default:   bus_rd_data = '0;
    endcase
  end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int RANGE_W  = 4,
  parameter int EXP_BASE = 16,
  parameter int CNT_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr_en,
  input logic [DATA_W-1:0]  bus_wr_data,
  input logic               en,
  input logic [RANGE_W-1:0] range,
  input logic [CNT_W-1:0]   cnt,
  input logic               timeout
);

  logic key_wr, start_wr;

  assign key_wr   = bus_wr_en && (bus_addr[3:2] == 2'd3) &&
                    (bus_wr_data == DATA_W'(KWD_KICK_KEY));
  assign start_wr = bus_wr_en && (bus_addr[3:2] == 2'd0) && bus_wr_data[0];

  function automatic logic [CNT_W-1:0] full_period(input logic [RANGE_W-1:0] r);
    return CNT_W'(1) << (EXP_BASE + int'(r));
  endfunction

  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0 && !timeout));

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && start_wr) |=> (en && cnt == full_period($past(range))));

  p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  p_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0 && !key_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0 && key_wr) |=> (cnt == full_period($past(range))));

  p_timeout_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt == CNT_W'(1) && !key_wr) |=> timeout);

  p_timeout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (timeout && cnt == '0));

endmodule

bind keyed_watchdog kwd_checker #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .RANGE_W (RANGE_W),
  .EXP_BASE(EXP_BASE),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr_en  (bus_wr_en),
  .bus_wr_data(bus_wr_data),
  .en         (en_q),
  .range      (range_q),
  .cnt        (cnt_q),
  .timeout    (timeout_o)
);

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int BASE   = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [DATA_W-1:0] bus_wr_data = '0;
  logic [DATA_W-1:0] bus_rd_data;
  logic              timeout_o;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] rd;

  // Each entry: {range code[15:12], idle cycles after restart[11:0]}.
  localparam int NVEC = 5;
  localparam logic [15:0] VEC [NVEC] = '{16'h1003, 16'h300A, 16'h5000, 16'h7064, 16'h2007};

  keyed_watchdog #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RANGE_W(4), .EXP_BASE(BASE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data), .timeout_o(timeout_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; exactly one rising edge captures the write.
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wr_data = '0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rd_data;
  endtask

  function automatic logic [DATA_W-1:0] period(input int n);
    return DATA_W'(1) << (BASE + n);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    bus_read(4'h0, rd); check("R1 ctrl", rd, 0);
    bus_read(4'h4, rd); check("R1 range", rd, 0);
    bus_read(4'h8, rd); check("R1 count", rd, 0);
    check("R1 timeout", DATA_W'(timeout_o), 0);

    // R4 range write then R2 enable loads period of stored code
    bus_write(4'h4, 32'h1);
    bus_read(4'h4, rd); check("R4 range readback", rd, 1);
    bus_write(4'h0, 32'h1);
    bus_read(4'h8, rd); check("R2 load on enable", rd, period(1));
    bus_read(4'h0, rd); check("R2 ctrl set", rd, 1);

    // Table of range codes and idle waits (R6, R5)
    for (int i = 0; i < NVEC; i++) begin
      int n; int w;
      n = int'(VEC[i][15:12]);
      w = int'(VEC[i][11:0]);
      bus_write(4'h4, DATA_W'(n));
      bus_write(4'hC, 32'h76);
      bus_read(4'h8, rd); check("R6 reload to period", rd, period(n));
      repeat (w) @(negedge clk);
      bus_read(4'h8, rd); check("R5 count after idle", rd, period(n) - DATA_W'(w));
      check("R8 no early timeout", DATA_W'(timeout_o), 0);
    end

    // Fresh long period for directed tests
    bus_write(4'h4, 32'd6);
    bus_write(4'hC, 32'h76);
    bus_read(4'h8, rd); check("R6 reload code 6", rd, 256);

    // R3 clearing write ignored
    bus_write(4'h0, 32'h0);
    bus_read(4'h0, rd); check("R3 still enabled", rd, 1);
    bus_read(4'h8, rd); check("R3 counting on", rd, 255);

    // R7 wrong keys
    bus_write(4'hC, 32'h75);
    bus_read(4'h8, rd); check("R7 key 0x75", rd, 254);
    bus_write(4'hC, 32'h176);
    bus_read(4'h8, rd); check("R7 key 0x176", rd, 253);

    // R10 count register is read-only
    bus_write(4'h8, 32'h5);
    bus_read(4'h8, rd); check("R10 count write ignored", rd, 252);

    // R4 upper bits dropped; R6 range change alone does not reload
    bus_write(4'h4, 32'hFFFF_FFF3);
    bus_read(4'h4, rd); check("R4 upper bits dropped", rd, 3);
    bus_read(4'h8, rd); check("R6 no reload on range write", rd, 251);

    // R9 decode
    bus_read(4'h9, rd); check("R9 low addr bits ignored", rd, 251);
    bus_read(4'hC, rd); check("R9 restart reads zero", rd, 0);
    bus_read(4'h3, rd); check("R9 ctrl alias", rd, 1);

    // R8 expiry with code 0 (period 4)
    bus_write(4'h4, 32'h0);
    bus_write(4'hC, 32'h76);
    bus_read(4'h8, rd); check("R8 reload 4", rd, 4);
    repeat (3) @(negedge clk);
    bus_read(4'h8, rd); check("R8 count 1", rd, 1);
    check("R8 timeout low at 1", DATA_W'(timeout_o), 0);
    @(negedge clk);
    bus_read(4'h8, rd); check("R8 count 0", rd, 0);
    check("R8 timeout rises", DATA_W'(timeout_o), 1);
    bus_write(4'hC, 32'h76);
    bus_read(4'h8, rd); check("R8 key after expiry", rd, 0);
    repeat (5) @(negedge clk);
    check("R8 timeout held", DATA_W'(timeout_o), 1);
    bus_read(4'h8, rd); check("R8 count held", rd, 0);

    // R1 reset clears; R11 key while disabled ignored
    do_reset();
    check("R1 timeout cleared", DATA_W'(timeout_o), 0);
    bus_read(4'h0, rd); check("R1 disabled after reset", rd, 0);
    bus_write(4'hC, 32'h76);
    repeat (2) @(negedge clk);
    bus_read(4'h8, rd); check("R11 count stays 0", rd, 0);
    bus_read(4'h0, rd); check("R11 stays disabled", rd, 0);
    check("R11 no timeout", DATA_W'(timeout_o), 0);

    finish_run();
  end

endmodule